// File: doc/BRIEF.md
# Data Translation Fault Status Unit

This block sits on the data side of a memory pipeline. It checks each load and store translation and either produces a physical address or a fault code. A request brings a 64-bit virtual address and a store flag. It also brings flags for a physical (untranslated) access, for alternate-mode use and for an access issued during a page-table walk. The current and alternate privilege modes, a privileged-code flag, a superpage enable and the result of an external TLB lookup come with it. The lookup result is a hit flag, a page frame number, per-mode read and write enables, and fault-on-read and fault-on-write bits.

On a fault the unit captures the faulting virtual address and a packed status word. The status word carries the instruction opcode, the destination register number and a set of cause flags. The unit also captures a formatted address: a page-table base ORed with the virtual page number shifted left by three. The three captured registers then freeze. Software releases them by reading the captured address with a read strobe. A fault that arrives while they are frozen still returns its fault code, but it leaves the captured values unchanged.

Top module: `dtfs_unit`

## Requirements
- R1: After reset, rsp_valid_o, locked_o, fault_va_o, mm_stat_o and va_form_o are all zero.
- R2: A physical access never faults, and its pa_o equals va_i[43:0].
- R3: A virtual address whose bits 63:42 are not all equal faults with code 2. Its cause flags are bad-VA plus access-violation, with write added for a store.
- R4: With sp_en_i set and va_i[42:41]==2'b10, the access is a superpage access. In kernel mode (mode 0) pa_o is va_i[39:0] with bits 43:40 all ones if va_i[40] or va_i[39] is set, and all zeros otherwise. In any other current mode it faults with code 1 and causes access-violation, plus write for a store.
- R5: A TLB miss sets the miss cause, plus write for a store. It reports code 4 when walk_i is set and code 3 otherwise.
- R6: When priv_i is set, the effective mode is alt_mode_i if alt_i is set and kernel (0) if not. When priv_i is clear, the effective mode is cur_mode_i. The effective mode selects bit [mode] of the read and write enables.
- R7: A store whose write enable is clear faults with code 2, causes write and access-violation, plus fault-on-write if the entry has it. A writable store with fault-on-write set faults with code 2 and causes write and fault-on-write. Any other store hit gives code 0.
- R8: A load whose read enable is clear faults with code 1, causes access-violation, plus fault-on-read if the entry has it. A readable load with fault-on-read set faults with code 2 and causes fault-on-read only.
- R9: The status word is {opcode_i[5:0], reg_i[4:0], cause[5:0]}, 17 bits. The cause bits from bit 0 upward are write, access-violation, fault-on-read, fault-on-write, miss, bad-VA.
- R10: The formatted address is ptbr_i | (va_i[42:13] << 3). The captured address is va_i itself.
- R11: A fault updates the three captured registers and sets locked_o only when locked_o is clear or va_rd_i is high in that cycle. A va_rd_i with no fault clears locked_o at the next edge.
- R12: Each request gives rsp_valid_o, pa_o and fault_o one edge later. A TLB hit with no fault gives pa_o = {pfn, va_i[12:0]}. Any fault gives pa_o = 0. Fault codes: 0 none, 1 access violation, 2 fault, 3 normal miss, 4 walk miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Request strobe |
| va_i | input | 64 | Virtual address |
| is_store_i | input | 1 | 1 = store, 0 = load |
| phys_i | input | 1 | Untranslated physical access |
| alt_i | input | 1 | Use alternate mode (privileged code only) |
| walk_i | input | 1 | Access issued by a page-table walk |
| priv_i | input | 1 | Privileged-code mode |
| cur_mode_i | input | 2 | Current mode (0 kernel, 3 user) |
| alt_mode_i | input | 2 | Alternate mode |
| sp_en_i | input | 1 | Superpage mapping enable |
| ptbr_i | input | 64 | Page-table base for the formatted address |
| opcode_i | input | 6 | Instruction opcode |
| reg_i | input | 5 | Destination register number |
| tlb_hit_i | input | 1 | TLB lookup hit |
| tlb_pfn_i | input | 31 | Page frame number |
| tlb_re_i | input | 4 | Read enable per mode |
| tlb_we_i | input | 4 | Write enable per mode |
| tlb_fonr_i | input | 1 | Fault-on-read bit |
| tlb_fonw_i | input | 1 | Fault-on-write bit |
| va_rd_i | input | 1 | Software read of the captured address |
| rsp_valid_o | output | 1 | Response valid |
| pa_o | output | 44 | Physical address |
| fault_o | output | 3 | Fault code |
| fault_va_o | output | 64 | Captured faulting address |
| mm_stat_o | output | 17 | Captured status word |
| va_form_o | output | 64 | Captured formatted address |
| locked_o | output | 1 | Captured registers frozen |

## Verification
The response and the captured registers both change at the first rising edge after the request strobe. Software sees each result one cycle after it issues the request. The driver applies a request just after a falling edge and pushes the expected response, with the expected captured-register state, into a queue. The monitor pops and compares at the next falling edge, half a cycle after the registers update. A read strobe rides on a request, so its effect on the lock appears in that request's response item.

// File: rtl/dtfs_pkg.sv
package dtfs_pkg;

    localparam int VA_W     = 64;
    localparam int VA_IMPL  = 43;
    localparam int PA_W     = 44;
    localparam int PG_BITS  = 13;
    localparam int PFN_W    = PA_W - PG_BITS;
    localparam int OPC_W    = 6;
    localparam int REG_W    = 5;
    localparam int MODE_W   = 2;
    localparam int NMODES   = 1 << MODE_W;
    localparam int CAUSE_W  = 6;
    localparam int STAT_W   = OPC_W + REG_W + CAUSE_W;
    localparam int VPN_W    = VA_IMPL - PG_BITS;
    localparam int SPC_LO   = VA_IMPL - 2;
    localparam int UNC_HI   = SPC_LO - 1;
    localparam int UNC_LO   = UNC_HI - 1;
    localparam int EXT_W    = PA_W - UNC_LO - 1;
    localparam logic [MODE_W-1:0] MODE_KERNEL = '0;

    typedef enum logic [2:0] {
        FC_NONE  = 3'd0,
        FC_ACV   = 3'd1,
        FC_FAULT = 3'd2,
        FC_NMISS = 3'd3,
        FC_PMISS = 3'd4
    } fault_e;

    typedef struct packed {
        logic badva;
        logic miss;
        logic fonw;
        logic fonr;
        logic acv;
        logic wr;
    } cause_t;

    typedef struct packed {
        logic [PFN_W-1:0]  pfn;
        logic [NMODES-1:0] re;
        logic [NMODES-1:0] we;
        logic              fonr;
        logic              fonw;
    } pte_t;

    function automatic logic va_ok(input logic [VA_W-1:0] va);
        return (&va[VA_W-1:VA_IMPL-1]) | ~(|va[VA_W-1:VA_IMPL-1]);
    endfunction

    function automatic logic [STAT_W-1:0] pack_stat(input logic [OPC_W-1:0] opc,
                                                    input logic [REG_W-1:0] rg,
                                                    input cause_t cause);
        return {opc, rg, cause};
    endfunction

endpackage

// File: rtl/dtfs_check.sv
module dtfs_check
    import dtfs_pkg::*;
(
    input  logic [VA_W-1:0]   va,
    input  logic              is_store,
    input  logic              phys,
    input  logic              alt,
    input  logic              walk,
    input  logic              priv,
    input  logic [MODE_W-1:0] cur_mode,
    input  logic [MODE_W-1:0] alt_mode,
    input  logic              sp_en,
    input  logic              hit,
    input  pte_t              pte,
    output fault_e            fault,
    output cause_t            cause,
    output logic [PA_W-1:0]   pa
);

    logic [MODE_W-1:0] eff_mode;
    logic              superpage;

    always_comb begin
        eff_mode  = priv ? (alt ? alt_mode : MODE_KERNEL) : cur_mode;
        superpage = sp_en && (va[VA_IMPL-1:SPC_LO] == 2'b10);
    end

    always_comb begin
        fault = FC_NONE;
        cause = '0;
        pa    = '0;
        if (phys) begin
            pa = va[PA_W-1:0];
        end else if (!va_ok(va)) begin
            fault       = FC_FAULT;
            cause.badva = 1'b1;
            cause.acv   = 1'b1;
            cause.wr    = is_store;
        end else if (superpage) begin
            if (cur_mode != MODE_KERNEL) begin
                fault     = FC_ACV;
                cause.acv = 1'b1;
                cause.wr  = is_store;
            end else if (va[UNC_HI] || va[UNC_LO]) begin
                pa = {{EXT_W{1'b1}}, va[UNC_LO:0]};
            end else begin
                pa = {{EXT_W{1'b0}}, va[UNC_LO:0]};
            end
        end else if (!hit) begin
            fault      = walk ? FC_PMISS : FC_NMISS;
            cause.miss = 1'b1;
            cause.wr   = is_store;
        end else begin
            pa = {pte.pfn, va[PG_BITS-1:0]};
            if (is_store) begin
                if (!pte.we[eff_mode]) begin
                    fault      = FC_FAULT;
                    cause.wr   = 1'b1;
                    cause.acv  = 1'b1;
                    cause.fonw = pte.fonw;
                end else if (pte.fonw) begin
                    fault      = FC_FAULT;
                    cause.wr   = 1'b1;
                    cause.fonw = 1'b1;
                end
            end else begin
                if (!pte.re[eff_mode]) begin
                    fault      = FC_ACV;
                    cause.acv  = 1'b1;
                    cause.fonr = pte.fonr;
                end else if (pte.fonr) begin
                    fault      = FC_FAULT;
                    cause.fonr = 1'b1;
                end
            end
        end
        if (fault != FC_NONE) pa = '0;
    end

endmodule

// File: rtl/dtfs_status.sv
module dtfs_status
    import dtfs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              fault_ev,
    input  logic              rd_va,
    input  logic [VA_W-1:0]   va,
    input  logic [OPC_W-1:0]  opc,
    input  logic [REG_W-1:0]  rg,
    input  cause_t            cause,
    input  logic [VA_W-1:0]   ptbr,
    output logic [VA_W-1:0]   fault_va,
    output logic [STAT_W-1:0] stat,
    output logic [VA_W-1:0]   va_form,
    output logic              locked
);

    logic            capture;
    logic [VA_W-1:0] form_d;

    always_comb begin
        capture = fault_ev && (!locked || rd_va);
        form_d  = ptbr | (VA_W'(va[VA_IMPL-1:PG_BITS]) << 3);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fault_va <= '0;
            stat     <= '0;
            va_form  <= '0;
            locked   <= 1'b0;
        end else begin
            if (capture) begin
                fault_va <= va;
                stat     <= pack_stat(opc, rg, cause);
                va_form  <= form_d;
            end
            if (fault_ev)   locked <= 1'b1;
            else if (rd_va) locked <= 1'b0;
        end
    end

endmodule

// File: rtl/dtfs_unit.sv
module dtfs_unit
    import dtfs_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              req_valid_i,
    input  logic [VA_W-1:0]   va_i,
    input  logic              is_store_i,
    input  logic              phys_i,
    input  logic              alt_i,
    input  logic              walk_i,
    input  logic              priv_i,
    input  logic [MODE_W-1:0] cur_mode_i,
    input  logic [MODE_W-1:0] alt_mode_i,
    input  logic              sp_en_i,
    input  logic [VA_W-1:0]   ptbr_i,
    input  logic [OPC_W-1:0]  opcode_i,
    input  logic [REG_W-1:0]  reg_i,
    input  logic              tlb_hit_i,
    input  logic [PFN_W-1:0]  tlb_pfn_i,
    input  logic [NMODES-1:0] tlb_re_i,
    input  logic [NMODES-1:0] tlb_we_i,
    input  logic              tlb_fonr_i,
    input  logic              tlb_fonw_i,
    input  logic              va_rd_i,
    output logic              rsp_valid_o,
    output logic [PA_W-1:0]   pa_o,
    output logic [2:0]        fault_o,
    output logic [VA_W-1:0]   fault_va_o,
    output logic [STAT_W-1:0] mm_stat_o,
    output logic [VA_W-1:0]   va_form_o,
    output logic              locked_o
);

    pte_t            pte;
    fault_e          fault_c;
    cause_t          cause_c;
    logic [PA_W-1:0] pa_c;
    logic            fault_ev;

    always_comb begin
        pte.pfn  = tlb_pfn_i;
        pte.re   = tlb_re_i;
        pte.we   = tlb_we_i;
        pte.fonr = tlb_fonr_i;
        pte.fonw = tlb_fonw_i;
        fault_ev = req_valid_i && (fault_c != FC_NONE);
    end

    dtfs_check u_check (
        .va       (va_i),
        .is_store (is_store_i),
        .phys     (phys_i),
        .alt      (alt_i),
        .walk     (walk_i),
        .priv     (priv_i),
        .cur_mode (cur_mode_i),
        .alt_mode (alt_mode_i),
        .sp_en    (sp_en_i),
        .hit      (tlb_hit_i),
        .pte      (pte),
        .fault    (fault_c),
        .cause    (cause_c),
        .pa       (pa_c)
    );

    dtfs_status u_status (
        .clk      (clk_i),
        .rst      (rst_i),
        .fault_ev (fault_ev),
        .rd_va    (va_rd_i),
        .va       (va_i),
        .opc      (opcode_i),
        .rg       (reg_i),
        .cause    (cause_c),
        .ptbr     (ptbr_i),
        .fault_va (fault_va_o),
        .stat     (mm_stat_o),
        .va_form  (va_form_o),
        .locked   (locked_o)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            rsp_valid_o <= 1'b0;
            pa_o        <= '0;
            fault_o     <= FC_NONE;
        end else begin
            rsp_valid_o <= req_valid_i;
            if (req_valid_i) begin
                pa_o    <= pa_c;
                fault_o <= fault_c;
            end
        end
    end

endmodule

// File: rtl/dtfs_sva.sv
module dtfs_sva
    import dtfs_pkg::*;
(
    input logic              clk_i,
    input logic              rst_i,
    input logic              req_valid_i,
    input logic              is_store_i,
    input logic              phys_i,
    input logic              va_rd_i,
    input logic              rsp_valid_o,
    input logic [2:0]        fault_o,
    input logic [PA_W-1:0]   pa_o,
    input logic [VA_W-1:0]   fault_va_o,
    input logic [STAT_W-1:0] mm_stat_o,
    input logic [VA_W-1:0]   va_form_o,
    input logic              locked_o
);

    AST_RSP_AFTER_REQ: assert property (@(posedge clk_i) disable iff (rst_i)
        req_valid_i |=> rsp_valid_o);  // R12

    AST_NO_RSP_IDLE: assert property (@(posedge clk_i) disable iff (rst_i)
        !req_valid_i |=> !rsp_valid_o);  // R12

    AST_FAULT_PA_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
        (rsp_valid_o && fault_o != 3'd0) |-> (pa_o == '0));  // R12

    AST_PHYS_NO_FAULT: assert property (@(posedge clk_i) disable iff (rst_i)
        (req_valid_i && phys_i) |=> (fault_o == 3'd0));  // R2

    AST_FAULT_LOCKS: assert property (@(posedge clk_i) disable iff (rst_i)
        (rsp_valid_o && fault_o != 3'd0) |-> locked_o);  // R11

    AST_LOCK_HOLDS: assert property (@(posedge clk_i) disable iff (rst_i)
        (locked_o && !va_rd_i) |=> ($stable(fault_va_o) && $stable(mm_stat_o)
                                    && $stable(va_form_o) && locked_o));  // R11

    AST_STORE_WR_FLAG: assert property (@(posedge clk_i) disable iff (rst_i)
        (req_valid_i && is_store_i && !phys_i && !locked_o)
            |=> ((fault_o == 3'd0) || mm_stat_o[0]));  // R7

endmodule

bind dtfs_unit dtfs_sva u_sva (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .req_valid_i (req_valid_i),
    .is_store_i  (is_store_i),
    .phys_i      (phys_i),
    .va_rd_i     (va_rd_i),
    .rsp_valid_o (rsp_valid_o),
    .fault_o     (fault_o),
    .pa_o        (pa_o),
    .fault_va_o  (fault_va_o),
    .mm_stat_o   (mm_stat_o),
    .va_form_o   (va_form_o),
    .locked_o    (locked_o)
);

// File: tb/dtfs_unit_tb.sv
module dtfs_unit_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_v = 1'b0;
    logic [63:0] va;
    logic        st, phys, alt, walk, priv, sp, hit, fonr, fonw, rd = 1'b0;
    logic [1:0]  cm, am;
    logic [63:0] ptbr;
    logic [5:0]  opc;
    logic [4:0]  rg;
    logic [30:0] pfn;
    logic [3:0]  ren, wen;

    logic        rsp_valid, locked;
    logic [43:0] pa;
    logic [2:0]  fault;
    logic [63:0] fva, form;
    logic [16:0] stat;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [2:0]  fault;
        logic [43:0] pa;
        logic [63:0] fva;
        logic [16:0] stat;
        logic [63:0] form;
        logic        lock;
        string       tag;
    } item_t;

    item_t q[$];

    logic        m_lock = 1'b0;
    logic [63:0] m_fva  = '0;
    logic [16:0] m_stat = '0;
    logic [63:0] m_form = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dtfs_unit u_dut (
        .clk_i(clk), .rst_i(rst), .req_valid_i(req_v), .va_i(va), .is_store_i(st),
        .phys_i(phys), .alt_i(alt), .walk_i(walk), .priv_i(priv), .cur_mode_i(cm),
        .alt_mode_i(am), .sp_en_i(sp), .ptbr_i(ptbr), .opcode_i(opc), .reg_i(rg),
        .tlb_hit_i(hit), .tlb_pfn_i(pfn), .tlb_re_i(ren), .tlb_we_i(wen),
        .tlb_fonr_i(fonr), .tlb_fonw_i(fonw), .va_rd_i(rd),
        .rsp_valid_o(rsp_valid), .pa_o(pa), .fault_o(fault), .fault_va_o(fva),
        .mm_stat_o(stat), .va_form_o(form), .locked_o(locked)
    );

    task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic clr();
        va = '0; st = 0; phys = 0; alt = 0; walk = 0; priv = 0; sp = 0; hit = 0;
        fonr = 0; fonw = 0; rd = 0; cm = 2'd0; am = 2'd0; ptbr = 64'h0000_0200_0000_0000;
        opc = 6'h29; rg = 5'd7; pfn = '0; ren = '0; wen = '0;
    endtask

    // Independent reference model of the requirements
    task automatic model(output logic [2:0] f, output logic [5:0] c, output logic [43:0] p);
        logic [1:0] em;
        logic       okva;
        em   = priv ? (alt ? am : 2'd0) : cm;                                  // R6
        okva = (va[63:42] == '0) || (va[63:42] == '1);
        f = 3'd0; c = 6'd0; p = '0;
        if (phys) p = va[43:0];                                                // R2
        else if (!okva) begin f = 3'd2; c = 6'h22 | {5'd0, st}; end            // R3
        else if (sp && va[42:41] == 2'b10) begin                               // R4
            if (cm != 2'd0) begin f = 3'd1; c = 6'h02 | {5'd0, st}; end
            else p = {(va[40] | va[39]) ? 4'hF : 4'h0, va[39:0]};
        end else if (!hit) begin f = walk ? 3'd4 : 3'd3; c = 6'h10 | {5'd0, st}; end  // R5
        else begin
            p = {pfn, va[12:0]};                                               // R12
            if (st) begin                                                      // R7
                if (!wen[em]) begin f = 3'd2; c = 6'h03 | (fonw ? 6'h08 : 6'h00); end
                else if (fonw) begin f = 3'd2; c = 6'h09; end
            end else begin                                                     // R8
                if (!ren[em]) begin f = 3'd1; c = 6'h02 | (fonr ? 6'h04 : 6'h00); end
                else if (fonr) begin f = 3'd2; c = 6'h04; end
            end
        end
        if (f != 3'd0) p = '0;
    endtask

    task automatic go(input string tag);
        item_t      it;
        logic [2:0] f;
        logic [5:0] c;
        logic [43:0] p;
        model(f, c, p);
        if (f != 3'd0 && (!m_lock || rd)) begin                                // R11
            m_fva  = va;                                                       // R10
            m_stat = {opc, rg, c};                                             // R9
            m_form = ptbr | ({34'd0, va[42:13]} << 3);                         // R10
        end
        if (f != 3'd0) m_lock = 1'b1;
        else if (rd)   m_lock = 1'b0;
        it.fault = f; it.pa = p; it.fva = m_fva; it.stat = m_stat;
        it.form = m_form; it.lock = m_lock; it.tag = tag;
        q.push_back(it);
        req_v = 1'b1;
        @(negedge clk);
        req_v = 1'b0;
        rd    = 1'b0;
    endtask

    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            if (q.size() == 0) begin
                checks++; fails++;
                $display("FAIL R12 unexpected response: actual 1 expected 0");
            end else begin
                item_t it;
                it = q.pop_front();
                chk(it.tag, "fault", {61'd0, fault}, {61'd0, it.fault});
                chk(it.tag, "pa", {20'd0, pa}, {20'd0, it.pa});
                chk(it.tag, "fault_va", fva, it.fva);
                chk(it.tag, "mm_stat", {47'd0, stat}, {47'd0, it.stat});
                chk(it.tag, "va_form", form, it.form);
                chk(it.tag, "locked", {63'd0, locked}, {63'd0, it.lock});
            end
        end
    end

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 20000) begin
                checks++; fails++;
                $display("FAIL watchdog: actual timeout expected completion");
                $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        clr();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1", "rsp_valid", {63'd0, rsp_valid}, 64'd0);
        chk("R1", "locked", {63'd0, locked}, 64'd0);
        chk("R1", "fault_va", fva, 64'd0);
        chk("R1", "mm_stat", {47'd0, stat}, 64'd0);
        chk("R1", "va_form", form, 64'd0);

        clr(); phys = 1; va = 64'h0000_0ABC_DEF0_1234; go("R2");
        clr(); phys = 1; st = 1; va = 64'hFFFF_F123_4567_89AB; go("R2");
        clr(); va = 64'h0000_1000_0012_4000; opc = 6'h28; rg = 5'd3; go("R3 R9 R10");
        clr(); va = 64'h0000_0001_2345_6000; go("R11 R5 held");
        clr(); phys = 1; rd = 1; go("R11 release");
        clr(); va = 64'h0000_0001_0000_2000; walk = 1; st = 1; opc = 6'h2D; rg = 5'd31; go("R5 walk");
        clr(); va = 64'h0000_0001_0000_4000; rd = 1; go("R5 R11 read-and-fault");
        clr(); phys = 1; rd = 1; go("R11");
        clr(); sp = 1; va = 64'hFFFF_FC80_1234_5000; go("R4 uncached");
        clr(); sp = 1; va = 64'hFFFF_FC00_1234_5000; go("R4 cached");
        clr(); sp = 1; va = 64'hFFFF_FC00_1234_5000; cm = 2'd3; st = 1; rd = 1; go("R4 user");
        clr(); va = 64'h0000_0000_0000_2ABC; st = 1; rd = 1; go("R3 store okva");
        clr(); hit = 1; pfn = 31'h1234_567; va = 64'h0000_0002_0000_1FFF; ren = 4'b0001; rd = 1; go("R8 R12 hit");
        clr(); hit = 1; va = 64'h0000_0002_0000_0010; fonr = 1; ren = 4'b1110; rd = 1; go("R8 acv");
        clr(); hit = 1; va = 64'h0000_0002_0000_0020; fonr = 1; ren = 4'b0001; rd = 1; go("R8 fonr");
        clr(); hit = 1; st = 1; va = 64'h0000_0002_0000_0030; fonw = 1; wen = 4'b1110; rd = 1; go("R7 acv");
        clr(); hit = 1; st = 1; va = 64'h0000_0002_0000_0040; fonw = 1; wen = 4'b0001; rd = 1; go("R7 fonw");
        clr(); hit = 1; st = 1; pfn = 31'h7FFF_FFFF; va = 64'h0000_0002_0000_0050; wen = 4'b0001; rd = 1; go("R7 ok");
        clr(); hit = 1; priv = 1; alt = 1; am = 2'd3; ren = 4'b1000; va = 64'h0000_0003_0000_0060; go("R6 alt");
        clr(); hit = 1; priv = 1; am = 2'd3; cm = 2'd3; ren = 4'b1000; va = 64'h0000_0003_0000_0070; rd = 1; go("R6 kernel");
        clr(); hit = 1; cm = 2'd2; alt = 1; am = 2'd0; ren = 4'b0100; va = 64'h0000_0003_0000_0080; rd = 1; go("R6 cur");
        repeat (3) @(negedge clk);
        chk("R12", "queue empty", 64'(q.size()), 64'd0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule